// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Interrupt and DMA Routing

This block receives asynchronous serial characters that carry a ninth data bit. Each character has a low start bit, nine data bits sent least significant bit first, and a high stop bit. Every accepted character is stored as a 9-bit word in a holding register. A mode field decides which characters are accepted. It also decides whether the CPU is signalled by an interrupt or a DMA engine is signalled by a request. The interrupt and DMA signals come from the same receive event.

Three modes are useful for multi-drop protocols. The address mode keeps only characters whose ninth bit is set. The plain mode keeps every character. The streaming mode hands every character to DMA, and in addition interrupts the CPU when the ninth bit is set, for example on a frame trailer. Line errors are framing error and overrun. They raise their own interrupt whatever the routing. The line is oversampled from an external tick at 16 times the bit rate. The transmitter is outside this block; only its ready flag passes through the interrupt gating.

Top module: `ninebit_rx`

## Requirements
- R1: After a synchronous reset, `rx_full`, `rx_data`, `dma_req`, `irq_rx`, `irq_tx`, `irq_err`, `framing_err` and `overrun_err` are all zero.
- R2: Each bit is decided by a majority of three samples taken at mid-bit on `os_tick`, with 16 ticks per bit. A line inversion that covers only one of those samples does not change the received value. `rx_data[8]` holds the ninth bit and `rx_data[7:0]` the first eight bits, in arrival order from bit 0 upward.
- R3: A low pulse that is back high by mid-start-bit is rejected as a false start. It delivers nothing, and the next real character is received correctly.
- R4: With `mode` = 3'b010, a character whose ninth bit is 0 is discarded and leaves every output unchanged. A character whose ninth bit is 1 is accepted.
- R5: With `mode` = 3'b011, every character is accepted, whatever its ninth bit.
- R6: With `mode` = 3'b111, every accepted character raises `dma_req`, and `irq_rx` is raised only for characters whose ninth bit is 1.
- R7: With `dma_en` = 1 in mode 3'b010 or 3'b011, an accepted character raises `dma_req` and does not raise `irq_rx`.
- R8: `irq_tx` follows `tx_ready` one cycle later, except that it is held at 0 while `dma_en` = 1 or `mode` = 3'b111.
- R9: A character whose stop bit samples low sets `framing_err` and `irq_err`, in every active mode including the DMA modes. The character is not delivered.
- R10: If a character is accepted while `rx_full` is still 1, `overrun_err` and `irq_err` are set and `rx_data` takes the newer character.
- R11: `rd_strobe` clears `rx_full`, `irq_rx` and `dma_req`. `dma_ack` clears `rx_full` and `dma_req` but leaves `irq_rx` set. `err_clr` clears `framing_err`, `overrun_err` and `irq_err`.
- R12: For any `mode` value other than 3'b010, 3'b011 and 3'b111, the receiver delivers nothing and flags no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| mode | input | 3 | Reception mode (010 address, 011 all, 111 DMA with trailer interrupt) |
| dma_en | input | 1 | Route accepted characters to DMA in modes 010 and 011 |
| tx_ready | input | 1 | Transmitter ready flag |
| rd_strobe | input | 1 | CPU read of the receive register |
| dma_ack | input | 1 | DMA acknowledge of the receive register |
| err_clr | input | 1 | Clear the error flags |
| rx_data | output | 9 | Received character, bit 8 is the ninth bit |
| rx_full | output | 1 | Receive register holds an unread character |
| dma_req | output | 1 | DMA request |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit-ready interrupt |
| irq_err | output | 1 | Line-error interrupt |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
The bench targets the mode-7 trailer case. A design that treated mode 7 like plain DMA would never interrupt on a ninth-bit-set character, and one that treated it like mode 3 would interrupt on every character. It also checks that an acknowledge leaves the trailer interrupt pending. Mode-2 characters with a clear ninth bit must leave the register and the overrun logic untouched; a design that slipped here would overwrite data or report a false overrun. Single-sample glitches, false starts and low stop bits are driven on purpose, since a receiver without a vote or without the start recheck would corrupt bits or deliver phantom characters. A design that dropped error interrupts under DMA would hide a framing error from the CPU.

// File: rtl/nbrx_pkg.sv
package nbrx_pkg;
  localparam logic [2:0] MODE_ADDR  = 3'b010;
  localparam logic [2:0] MODE_ALL   = 3'b011;
  localparam logic [2:0] MODE_DMA9  = 3'b111;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/nbrx_sync.sv
module nbrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/nbrx_sampler.sv
module nbrx_sampler
  import nbrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line,
  output logic             done,
  output logic [NBITS-1:0] word,
  output logic             stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] SMP0 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SMP1 = CW'(OSR/2);
  localparam logic [CW-1:0] SMP2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] BLAST = IW'(NBITS - 1);

  rx_state_e        state;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    bidx;
  logic [1:0]       smp;
  logic [NBITS-1:0] shreg;
  logic             vote;

  // two of three: the two stored samples plus the live one
  assign vote = (smp[0] & smp[1]) | (smp[0] & line) | (smp[1] & line);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      smp     <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      word    <= '0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          cnt <= '0;
          if (!line) state <= RX_START;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == SMP0) smp[0] <= line;
          if (cnt == SMP1) smp[1] <= line;
          case (state)
            RX_START: begin
              if (cnt == SMP2 && vote) state <= RX_IDLE;   // false start
              else if (cnt == LAST) begin
                state <= RX_DATA;
                cnt   <= '0;
                bidx  <= '0;
              end
            end
            RX_DATA: begin
              if (cnt == SMP2) shreg <= {vote, shreg[NBITS-1:1]};
              if (cnt == LAST) begin
                cnt <= '0;
                if (bidx == BLAST) state <= RX_STOP;
                else               bidx  <= bidx + 1'b1;
              end
            end
            RX_STOP: begin
              if (cnt == SMP2) begin
                done    <= 1'b1;
                word    <= shreg;
                stop_ok <= vote;
                state   <= RX_IDLE;
              end
            end
            default: state <= RX_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nbrx_route.sv
module nbrx_route
  import nbrx_pkg::*;
#(
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             char_done,
  input  logic [NBITS-1:0] char_data,
  input  logic             char_stop_ok,
  input  logic [2:0]       mode,
  input  logic             dma_en,
  input  logic             rd_strobe,
  input  logic             dma_ack,
  input  logic             err_clr,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_full,
  output logic             dma_req,
  output logic             irq_rx,
  output logic             framing_err,
  output logic             overrun_err,
  output logic             irq_err
);
  logic active, dma_mode, ninth, take, fe_ev, ov_ev, fe_nx, ov_nx, drained;

  assign active   = (mode == MODE_ADDR) || (mode == MODE_ALL) || (mode == MODE_DMA9);
  assign dma_mode = dma_en || (mode == MODE_DMA9);
  assign ninth    = char_data[NBITS-1];
  assign take     = char_done && char_stop_ok && active && ((mode != MODE_ADDR) || ninth);
  assign fe_ev    = char_done && !char_stop_ok && active;
  assign drained  = rd_strobe || dma_ack;
  assign ov_ev    = take && rx_full && !drained;
  assign fe_nx    = fe_ev || (framing_err && !err_clr);
  assign ov_nx    = ov_ev || (overrun_err && !err_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      dma_req     <= 1'b0;
      irq_rx      <= 1'b0;
      framing_err <= 1'b0;
      overrun_err <= 1'b0;
      irq_err     <= 1'b0;
    end else begin
      if (take) rx_data <= char_data;

      if (take)         rx_full <= 1'b1;
      else if (drained) rx_full <= 1'b0;

      if (take && dma_mode) dma_req <= 1'b1;
      else if (drained)     dma_req <= 1'b0;

      if (take && (!dma_mode || (mode == MODE_DMA9 && ninth))) irq_rx <= 1'b1;
      else if (rd_strobe)                                      irq_rx <= 1'b0;

      framing_err <= fe_nx;
      overrun_err <= ov_nx;
      irq_err     <= fe_nx || ov_nx;
    end
  end
endmodule

// File: rtl/ninebit_rx.sv
module ninebit_rx
  import nbrx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int NBITS     = 9,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic [2:0]       mode,
  input  logic             dma_en,
  input  logic             tx_ready,
  input  logic             rd_strobe,
  input  logic             dma_ack,
  input  logic             err_clr,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_full,
  output logic             dma_req,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_err,
  output logic             framing_err,
  output logic             overrun_err
);
  logic             line_s;
  logic             char_done;
  logic [NBITS-1:0] char_data;
  logic             char_stop_ok;

  nbrx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  nbrx_sampler #(.OSR(OSR), .NBITS(NBITS)) u_smp (
    .clk(clk), .rst(rst), .tick(os_tick), .line(line_s),
    .done(char_done), .word(char_data), .stop_ok(char_stop_ok)
  );

  nbrx_route #(.NBITS(NBITS)) u_route (
    .clk(clk), .rst(rst),
    .char_done(char_done), .char_data(char_data), .char_stop_ok(char_stop_ok),
    .mode(mode), .dma_en(dma_en),
    .rd_strobe(rd_strobe), .dma_ack(dma_ack), .err_clr(err_clr),
    .rx_data(rx_data), .rx_full(rx_full), .dma_req(dma_req), .irq_rx(irq_rx),
    .framing_err(framing_err), .overrun_err(overrun_err), .irq_err(irq_err)
  );

  // transmit-ready interrupt is gated off while characters go to DMA
  always_ff @(posedge clk) begin
    if (rst) irq_tx <= 1'b0;
    else     irq_tx <= tx_ready && !(dma_en || mode == MODE_DMA9);
  end
endmodule

// File: rtl/nbrx_checker.sv
module nbrx_checker #(
  parameter int NBITS = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode,
  input logic             dma_en,
  input logic             rd_strobe,
  input logic             dma_ack,
  input logic             char_done,
  input logic             char_ninth,
  input logic             char_stop_ok,
  input logic [NBITS-1:0] rx_data,
  input logic             rx_full,
  input logic             dma_req,
  input logic             irq_rx,
  input logic             irq_tx,
  input logic             overrun_err
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rx_full && !dma_req && !irq_rx && !irq_tx && !overrun_err));

  p_addr_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (char_done && mode == 3'b010 && !char_ninth && !rd_strobe && !dma_ack)
      |=> ($stable(rx_data) && $stable(rx_full)));

  p_dma_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(dma_en || mode == 3'b111));

  p_tx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_en || mode == 3'b111) |=> !irq_tx);

  p_fe_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (char_done && !char_stop_ok && !rd_strobe && !dma_ack)
      |=> ($stable(rx_full) && $stable(rx_data)));

  p_ovr_full_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_err) |-> $past(rx_full));

  p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !char_done) |=> !dma_req);
endmodule

bind ninebit_rx nbrx_checker #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .dma_en(dma_en),
  .rd_strobe(rd_strobe), .dma_ack(dma_ack),
  .char_done(char_done), .char_ninth(char_data[NBITS-1]),
  .char_stop_ok(char_stop_ok),
  .rx_data(rx_data), .rx_full(rx_full), .dma_req(dma_req),
  .irq_rx(irq_rx), .irq_tx(irq_tx), .overrun_err(overrun_err)
);

// File: tb/sim_ninebit_rx.sv
`timescale 1ns/1ps
module sim_ninebit_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rxd = 1'b1;
  logic [2:0] mode = 3'b011;
  logic       dma_en = 1'b0, tx_ready = 1'b0;
  logic       rd_strobe = 1'b0, dma_ack = 1'b0, err_clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, dma_req, irq_rx, irq_tx, irq_err, framing_err, overrun_err;

  always #10 clk = ~clk;

  ninebit_rx u0 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .mode(mode),
    .dma_en(dma_en), .tx_ready(tx_ready), .rd_strobe(rd_strobe),
    .dma_ack(dma_ack), .err_clr(err_clr), .rx_data(rx_data),
    .rx_full(rx_full), .dma_req(dma_req), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_err(irq_err), .framing_err(framing_err), .overrun_err(overrun_err)
  );

  int checks = 0, errors = 0;
  logic       m_full = 0, m_dreq = 0, m_irq = 0, m_fe = 0, m_ovr = 0;
  logic [8:0] m_data = '0;

  function automatic bit mode_active(logic [2:0] m);
    return m == 3'b010 || m == 3'b011 || m == 3'b111;
  endfunction
  function automatic bit accepts(logic [2:0] m, logic [8:0] d);
    return mode_active(m) && (m != 3'b010 || d[8]);
  endfunction
  function automatic bit uses_dma(logic [2:0] m, logic de);
    return de || m == 3'b111;
  endfunction
  function automatic string mode_tag(logic [2:0] m);
    if (m == 3'b010) return "R4";
    if (m == 3'b011) return "R5";
    if (m == 3'b111) return "R6";
    return "R12";
  endfunction

  task automatic chk(string req, string what, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "rx_full", 9'(rx_full), 9'(m_full));
    chk(req, "rx_data", rx_data, m_data);
    chk(req, "dma_req", 9'(dma_req), 9'(m_dreq));
    chk(req, "irq_rx", 9'(irq_rx), 9'(m_irq));
    chk(req, "framing_err", 9'(framing_err), 9'(m_fe));
    chk(req, "overrun_err", 9'(overrun_err), 9'(m_ovr));
    chk(req, "irq_err", 9'(irq_err), 9'(m_fe | m_ovr));
    chk(req, "irq_tx", 9'(irq_tx), 9'(tx_ready && !uses_dma(mode, dma_en)));
  endtask

  task automatic model_frame(logic [8:0] d, bit stop_ok);
    if (!mode_active(mode)) return;
    if (!stop_ok) begin m_fe = 1; return; end
    if (!accepts(mode, d)) return;
    if (m_full) m_ovr = 1;
    m_full = 1;
    m_data = d;
    if (uses_dma(mode, dma_en)) m_dreq = 1;
    if (!uses_dma(mode, dma_en) || (mode == 3'b111 && d[8])) m_irq = 1;
  endtask

  // one frame: start, nine bits LSB first, stop; optional one-clock glitch
  task automatic send_frame(logic [8:0] d, bit stop_ok, int glitch_bit);
    logic [10:0] bits;
    bits = {stop_ok, d, 1'b0};
    for (int b = 0; b < 11; b++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd = (b == glitch_bit && c == 8) ? ~bits[b] : bits[b];
      end
    @(negedge clk) rxd = 1'b1;
    repeat (24) @(negedge clk);
    model_frame(d, stop_ok);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    m_full = 0; m_irq = 0; m_dreq = 0;
    repeat (2) @(negedge clk);
  endtask
  task automatic do_ack();
    @(negedge clk) dma_ack = 1'b1;
    @(negedge clk) dma_ack = 1'b0;
    m_full = 0; m_dreq = 0;
    repeat (2) @(negedge clk);
  endtask
  task automatic do_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    m_fe = 0; m_ovr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0009));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1");                                    // reset state

    mode = 3'b011;
    send_frame(9'h0A5, 1, -1); check_state("R5");         // R5 ninth bit clear accepted
    do_read();                 check_state("R11");
    send_frame(9'h15C, 1, -1); check_state("R5");
    do_read();

    mode = 3'b010;
    send_frame(9'h055, 1, -1); check_state("R4");         // R4 dropped
    send_frame(9'h1C3, 1, -1); check_state("R4");         // R4 accepted
    do_read();

    mode = 3'b111;
    send_frame(9'h012, 1, -1); check_state("R6");         // dma only
    do_ack();                  check_state("R11");
    send_frame(9'h1FF, 1, -1); check_state("R6");         // dma plus trailer irq
    do_ack();                  check_state("R11");        // irq_rx survives ack
    do_read();                 check_state("R11");

    mode = 3'b011; dma_en = 1'b1; tx_ready = 1'b1;
    send_frame(9'h033, 1, -1); check_state("R7");         // R7 and R8
    dma_en = 1'b0;
    repeat (2) @(negedge clk); check_state("R8");
    do_ack();

    mode = 3'b111;
    send_frame(9'h044, 0, -1); check_state("R9");         // framing error under dma
    do_clr();                  check_state("R11");

    mode = 3'b011;
    send_frame(9'h101, 1, -1);
    send_frame(9'h0EE, 1, -1); check_state("R10");        // overrun keeps newer
    do_read(); do_clr();       check_state("R10");

    send_frame(9'h15A, 1, 4);  check_state("R2");         // glitch on bit 3
    do_read();
    send_frame(9'h0C7, 1, 9);  check_state("R2");         // glitch on ninth bit
    do_read();

    for (int c = 0; c < 4; c++) begin @(negedge clk); rxd = 1'b0; end
    @(negedge clk) rxd = 1'b1;
    repeat (40) @(negedge clk); check_state("R3");        // false start dropped
    send_frame(9'h1A6, 1, -1); check_state("R3");
    do_read();

    mode = 3'b000;
    send_frame(9'h1AA, 1, -1); check_state("R12");
    mode = 3'b101;
    send_frame(9'h0F0, 0, -1); check_state("R12");

    for (int i = 0; i < 40; i++) begin
      logic [2:0] modes [5] = '{3'b010, 3'b011, 3'b111, 3'b000, 3'b110};
      int act;
      @(negedge clk);
      mode     = modes[$urandom_range(4)];
      dma_en   = 1'($urandom_range(1));
      tx_ready = 1'($urandom_range(1));
      send_frame(9'($urandom_range(511)), ($urandom_range(9) != 0), -1);
      check_state(mode_tag(mode));
      act = $urandom_range(3);
      if (act == 1) begin do_read(); check_state("R11"); end
      else if (act == 2) begin do_ack(); check_state("R11"); end
      else if (act == 3) begin do_clr(); check_state("R11"); end
    end
    finish_run();
  end
endmodule